// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream and keeps or discards each 188-byte packet according to its packet identifier. Bytes arrive with a valid strobe and a start-of-packet flag. The block locks onto a packet when the start flag coincides with the sync value 0x47. It takes the 13-bit identifier from the second and third bytes and compares it against a small bank of programmable match slots. The packet then leaves on a byte-wide output with its own start marker, either complete or not at all.

Each slot has its own 32-bit configuration word, written through a simple write port. The word for slot 0 also carries two stream-wide controls. One forwards every packet. The other mutes the output entirely. Writes land in a shadow copy. The copy that drives the decisions is refreshed only between packets, so a packet is always judged against one consistent set of settings.

Top module: `ts_pid_filter`

## Requirements
- R1: A packet begins on an accepted byte (in_valid high) that has in_sop set and the value 0x47 while no packet is open. It then spans exactly 188 accepted bytes. An in_sop pulse inside an open packet is treated as ordinary payload.
- R2: While no packet is open, every accepted byte that is not both flagged by in_sop and equal to 0x47 is discarded. Cycles with in_valid low are never taken as a start.
- R3: The identifier is the low 5 bits of packet byte 1 (as identifier bits 12:8) joined with all of byte 2 (as bits 7:0). The upper 3 bits of byte 1 play no part.
- R4: Writing word n on the configuration port (cfg_addr = n) programs slot n. Bits 12:0 hold the identifier and bit 15 the slot enable. A packet matches when some enabled slot holds its identifier, and a matching packet is forwarded.
- R5: A slot with its enable clear never matches, even when its identifier field equals the packet's. After reset every slot is disabled and holds 0x1FFF.
- R6: Bit 16 of the slot-0 word forwards every packet, whatever the slots hold.
- R7: Bit 13 of the slot-0 word mutes the block: no packet is forwarded. This takes priority over bit 16.
- R8: A forwarded packet appears on the output as all 188 bytes in order, with out_sop high on the first byte only (0x47). A dropped packet produces no output byte.
- R9: A configuration write applies only to packets whose sync byte is accepted in a later cycle than the write. A write in the same cycle as a sync byte, or during a packet, leaves that packet judged by the earlier settings.
- R10: Packets arriving back to back with no idle cycle are all handled. The last bytes of one and the first bytes of the next never overlap or reorder on the output.
- R11: Under reset and directly after it, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | Input start-of-packet flag |
| in_data | input | 8 | Input stream byte |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW (3) | Slot word index |
| cfg_wdata | input | 32 | Configuration word |
| out_valid | output | 1 | Output byte strobe |
| out_sop | output | 1 | Output first-byte marker |
| out_data | output | 8 | Output stream byte |

## Verification
Two events can land in the same clock: a configuration write, and the acceptance of a packet's sync byte. The bench drives a slot write in exactly the cycle that carries 0x47 with in_sop. It expects that packet to follow the old settings and the following packet to follow the new ones. It repeats the check with the write placed in the middle of a packet. A second overlap is the two-byte tail of one packet draining while the next packet's header bytes arrive. Back-to-back packets with no idle cycle provoke it, and the scoreboard judges it by comparing the output byte order and start markers.

// File: rtl/ts_filt_pkg.sv
package ts_filt_pkg;
  localparam int PID_W    = 13;
  localparam int REG_W    = 32;
  localparam int HDR_LEN  = 3;      // bytes needed before a decision
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam int EN_BIT   = 15;
  localparam int PASS_BIT = 16;
  localparam int MUTE_BIT = 13;
  localparam logic [PID_W-1:0] PARK_PID = 13'h1FFF;
endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import ts_filt_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int AW    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [REG_W-1:0]            wdata,
  input  logic                        load,
  output logic [NSLOT-1:0][PID_W-1:0] act_pid,
  output logic [NSLOT-1:0]            act_en,
  output logic                        act_pass,
  output logic                        act_mute
);
  logic [NSLOT-1:0][PID_W-1:0] sh_pid;
  logic [NSLOT-1:0]            sh_en;
  logic                        sh_pass, sh_mute;
  logic                        unused_bits;

  assign unused_bits = ^{wdata[REG_W-1:PASS_BIT+1], wdata[EN_BIT-1]};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_pid[i]  <= PARK_PID;
        sh_en[i]   <= 1'b0;
        act_pid[i] <= PARK_PID;
        act_en[i]  <= 1'b0;
      end else begin
        if (we && addr == AW'(i)) begin
          sh_pid[i] <= wdata[PID_W-1:0];
          sh_en[i]  <= wdata[EN_BIT];
        end
        if (load) begin
          act_pid[i] <= sh_pid[i];
          act_en[i]  <= sh_en[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_pass  <= 1'b0;
      sh_mute  <= 1'b0;
      act_pass <= 1'b0;
      act_mute <= 1'b0;
    end else begin
      if (we && addr == '0) begin
        sh_pass <= wdata[PASS_BIT];
        sh_mute <= wdata[MUTE_BIT];
      end
      if (load) begin
        act_pass <= sh_pass;
        act_mute <= sh_mute;
      end
    end
  end
endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match
  import ts_filt_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic [PID_W-1:0]            pid,
  input  logic [NSLOT-1:0][PID_W-1:0] slot_pid,
  input  logic [NSLOT-1:0]            slot_en,
  output logic                        hit
);
  logic [NSLOT-1:0] eq;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign eq[i] = slot_en[i] && (slot_pid[i] == pid);
  end

  assign hit = |eq;
endmodule

// File: rtl/ts_pkt_gate.sv
module ts_pkt_gate
  import ts_filt_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic             hit,
  input  logic             pass_all,
  input  logic             mute,
  output logic [PID_W-1:0] pid,
  output logic             busy,
  output logic             out_valid,
  output logic             out_sop,
  output logic [7:0]       out_data
);
  localparam int CW = $clog2(PKT_LEN + 1);
  localparam logic [CW-1:0] IDX_DEC  = CW'(HDR_LEN - 1);
  localparam logic [CW-1:0] IDX_LAST = CW'(PKT_LEN - 1);

  logic          in_pkt;
  logic [CW-1:0] cnt;
  logic [7:0]    sr0, sr1;      // sr0 older byte, sr1 newer byte
  logic          keep;
  logic [7:0]    fl0, fl1;      // tail bytes still to drain
  logic [1:0]    fl_n;

  logic start, take, is_dec, is_last, fwd, main_emit, fl_emit;

  assign start     = in_valid && !in_pkt && in_sop && (in_data == SYNC_BYTE);
  assign take      = in_valid && in_pkt;
  assign is_dec    = take && (cnt == IDX_DEC);
  assign is_last   = take && (cnt == IDX_LAST);
  assign pid       = {sr1[PID_W-9:0], in_data};
  assign fwd       = !mute && (pass_all || hit);
  assign main_emit = take && (cnt >= IDX_DEC) && (is_dec ? fwd : keep);
  assign fl_emit   = (fl_n != 2'd0);
  assign busy      = in_pkt;

  // framing
  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0;
      cnt    <= '0;
      sr0    <= '0;
      sr1    <= '0;
      keep   <= 1'b0;
    end else begin
      if (start) begin
        in_pkt <= 1'b1;
        cnt    <= CW'(1);
      end else if (take) begin
        if (is_last) begin
          in_pkt <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (start || take) begin
        sr0 <= sr1;
        sr1 <= in_data;
      end
      if (is_dec) keep <= fwd;
    end
  end

  // tail drain
  always_ff @(posedge clk) begin
    if (rst) begin
      fl0  <= '0;
      fl1  <= '0;
      fl_n <= 2'd0;
    end else if (is_last) begin
      fl0  <= sr1;
      fl1  <= in_data;
      fl_n <= keep ? 2'd2 : 2'd0;
    end else if (fl_emit) begin
      fl0  <= fl1;
      fl_n <= fl_n - 2'd1;
    end
  end

  // registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= main_emit || fl_emit;
      out_sop   <= main_emit && is_dec;
      out_data  <= main_emit ? sr0 : fl0;
    end
  end

  // R8: the first output byte of a packet is always the sync value
  p_head_sync_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |-> (out_data == SYNC_BYTE));

  // R10: draining tail never shares a cycle with a new packet's bytes
  p_no_collide_r10: assert property (@(posedge clk) disable iff (rst)
    fl_emit |-> !main_emit);

  // R7: mute suppresses the head byte of the judged packet
  p_mute_r7: assert property (@(posedge clk) disable iff (rst)
    (is_dec && mute) |=> !out_valid);

  // R6: pass-all forwards the head byte of the judged packet
  p_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (is_dec && pass_all && !mute) |=> (out_valid && out_sop));

  // R2: a non-sync byte outside a packet never opens one
  p_hunt_r2: assert property (@(posedge clk) disable iff (rst)
    (!in_pkt && !(in_valid && in_sop && in_data == SYNC_BYTE)) |=> !in_pkt);
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_filt_pkg::*;
#(
  parameter int NSLOT   = 8,
  parameter int PKT_LEN = 188,
  localparam int AW     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             out_valid,
  output logic             out_sop,
  output logic [7:0]       out_data
);
  logic [NSLOT-1:0][PID_W-1:0] act_pid;
  logic [NSLOT-1:0]            act_en;
  logic                        act_pass, act_mute;
  logic [PID_W-1:0]            pid;
  logic                        hit, busy;

  ts_cfg_regs #(.NSLOT(NSLOT), .AW(AW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .load     (!busy),
    .act_pid  (act_pid),
    .act_en   (act_en),
    .act_pass (act_pass),
    .act_mute (act_mute)
  );

  ts_pid_match #(.NSLOT(NSLOT)) u_match (
    .pid      (pid),
    .slot_pid (act_pid),
    .slot_en  (act_en),
    .hit      (hit)
  );

  ts_pkt_gate #(.PKT_LEN(PKT_LEN)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_data   (in_data),
    .hit       (hit),
    .pass_all  (act_pass),
    .mute      (act_mute),
    .pid       (pid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_data  (out_data)
  );

  // R9: settings in force stay frozen while a packet is open
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(act_pid) && $stable(act_en) && $stable(act_pass) && $stable(act_mute)));
endmodule

// File: tb/ts_pid_filter_tb_top.sv
`timescale 1ns/1ps
module ts_pid_filter_tb_top;
  localparam int NSLOT = 8;
  localparam int PLEN  = 188;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_sop;
  logic [7:0]  in_data;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        out_valid, out_sop;
  logic [7:0]  out_data;

  always #2.5 clk = ~clk;

  ts_pid_filter #(.NSLOT(NSLOT), .PKT_LEN(PLEN)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data));

  typedef struct { logic [7:0] d; logic s; string tag; } exp_t;
  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // bench model of the shadow settings
  logic [12:0] m_pid [NSLOT];
  logic        m_en  [NSLOT];
  logic        m_pass, m_mute;

  function automatic void model_reset();
    for (int i = 0; i < NSLOT; i++) begin m_pid[i] = 13'h1FFF; m_en[i] = 1'b0; end
    m_pass = 1'b0; m_mute = 1'b0;
  endfunction

  function automatic void model_write(int a, logic [31:0] w);
    m_pid[a] = w[12:0];
    m_en[a]  = w[15];
    if (a == 0) begin m_pass = w[16]; m_mute = w[13]; end
  endfunction

  function automatic bit model_fwd(logic [12:0] pid);
    if (m_mute) return 1'b0;
    if (m_pass) return 1'b1;
    for (int i = 0; i < NSLOT; i++) if (m_en[i] && m_pid[i] == pid) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] pbyte(int i, logic [12:0] pid, int seed);
    if (i == 0) return 8'h47;
    if (i == 1) return {3'b010, pid[12:8]};
    if (i == 2) return pid[7:0];
    return 8'((seed * 7 + i) & 8'hFF);
  endfunction

  task automatic step(logic v, logic s, logic [7:0] d, logic we, logic [2:0] a, logic [31:0] w);
    @(posedge clk); #1;
    in_valid = v; in_sop = s; in_data = d;
    cfg_we = we; cfg_addr = a; cfg_wdata = w;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic cfg_write(int a, logic [31:0] w);
    step(1'b0, 1'b0, 8'h00, 1'b1, 3'(a), w);
    model_write(a, w);
  endtask

  // widx >= 0: a config write rides along with byte widx
  task automatic send_pkt(logic [12:0] pid, int seed, bit gap, int widx, int wa,
                          logic [31:0] wd, bit midsop, string tag);
    bit fwd;
    fwd = model_fwd(pid);
    if (widx >= 0) model_write(wa, wd);
    for (int i = 0; i < PLEN; i++) begin
      logic [7:0] b;
      logic s;
      b = (midsop && i == 50) ? 8'h47 : pbyte(i, pid, seed);
      s = (i == 0) || (midsop && i == 50);
      if (fwd) q.push_back('{d: b, s: (i == 0), tag: tag});
      step(1'b1, s, b, (i == widx), 3'(wa), wd);
      if (gap && (i % 3 == 1)) step(1'b0, 1'b1, 8'h47, 1'b0, 3'd0, 32'd0);
    end
  endtask

  task automatic check_drain(string tag);
    idle(12);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected bytes never appeared (actual %0d, expected 0)", tag, q.size(), q.size());
    end
    q.delete();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected output byte actual %h sop %0b, expected none", out_data, out_sop);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_data !== e.d || out_sop !== e.s) begin
          errors++;
          $display("FAIL %s: actual %h sop %0b, expected %h sop %0b", e.tag, out_data, out_sop, e.d, e.s);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual timeout, expected finish)");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    model_reset();
    rst = 1'b1;
    in_valid = 0; in_sop = 0; in_data = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R11: out_valid actual %b expected 0 in reset", out_valid); end
    end
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R11: out_valid actual %b expected 0 after reset", out_valid); end
    end

    // R5: reset state parks all slots at 0x1FFF disabled
    send_pkt(13'h1FFF, 1, 0, -1, 0, 0, 0, "R5");
    send_pkt(13'h0000, 2, 0, -1, 0, 0, 0, "R5");
    check_drain("R5");

    // R4 / R3: slot 3 matches; byte 1 upper bits are set to 010
    cfg_write(3, 32'h0000_8100);
    send_pkt(13'h0100, 3, 1, -1, 0, 0, 0, "R4");
    send_pkt(13'h0101, 4, 0, -1, 0, 0, 0, "R3");
    check_drain("R4");

    // R5: disabled slot holding the identifier does not match
    cfg_write(5, 32'h0000_1ABC);
    send_pkt(13'h1ABC, 5, 0, -1, 0, 0, 0, "R5");
    check_drain("R5");
    cfg_write(7, 32'h0000_9ABC);
    send_pkt(13'h1ABC, 6, 0, -1, 0, 0, 0, "R4");
    check_drain("R4");

    // R6: pass-all
    cfg_write(0, 32'h0001_1FFF);
    send_pkt(13'h0042, 7, 1, -1, 0, 0, 0, "R6");
    check_drain("R6");

    // R7: mute overrides pass-all and slot matches
    cfg_write(0, 32'h0001_3FFF);
    send_pkt(13'h0100, 8, 0, -1, 0, 0, 0, "R7");
    send_pkt(13'h0042, 9, 0, -1, 0, 0, 0, "R7");
    check_drain("R7");
    cfg_write(0, 32'h0000_1FFF);

    // R9: write in the sync-byte cycle, then a write mid-packet
    send_pkt(13'h0200, 10, 0, 0, 1, 32'h0000_8200, 0, "R9");
    send_pkt(13'h0200, 11, 0, -1, 0, 0, 0, "R9");
    send_pkt(13'h0200, 12, 0, 100, 1, 32'h0000_0200, 0, "R9");
    send_pkt(13'h0200, 13, 0, -1, 0, 0, 0, "R9");
    check_drain("R9");

    // R2: hunting discards non-start bytes
    step(1'b1, 1'b0, 8'h47, 1'b0, 3'd0, 32'd0);
    step(1'b1, 1'b1, 8'h12, 1'b0, 3'd0, 32'd0);
    step(1'b0, 1'b1, 8'h47, 1'b0, 3'd0, 32'd0);
    step(1'b1, 1'b0, 8'h00, 1'b0, 3'd0, 32'd0);
    send_pkt(13'h0100, 14, 0, -1, 0, 0, 0, "R2");
    check_drain("R2");

    // R1: start flag with sync value inside a packet is payload
    send_pkt(13'h0100, 15, 0, -1, 0, 0, 1, "R1");
    send_pkt(13'h0100, 16, 1, -1, 0, 0, 0, "R1");
    check_drain("R1");

    // R10: back-to-back keep / drop / keep / keep, no idle cycles
    send_pkt(13'h0100, 17, 0, -1, 0, 0, 0, "R10");
    send_pkt(13'h0333, 18, 0, -1, 0, 0, 0, "R10");
    send_pkt(13'h1ABC, 19, 0, -1, 0, 0, 0, "R10");
    send_pkt(13'h0100, 20, 0, -1, 0, 0, 0, "R10");
    check_drain("R10");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule